// File: doc/BRIEF.md
# Amplifier Mode and Protection Controller

This block supervises a two-channel switching audio power stage. Two control inputs select one of three operating modes. A run request held low means standby. With the run request high, a play request held low gives mute and a play request held high gives play. Five fault flags from the analog front end are combined with the selected mode: supply overvoltage, supply undervoltage, output overcurrent, thermal warning and thermal shutdown. These flags have already been digitized but are not yet synchronous to the block's clock.

The controller drives four commands to the power stage and the modulator:
- an output enable; when it is low the bridge outputs are high impedance,
- a force-mute command; the modulator then grounds its inputs and runs both bridge legs at an even 50% duty,
- a power-down command,
- a diagnostic flag that models an open-drain pin released while any protection is active.

Supply faults and thermal faults recover by themselves once their flag clears. An overcurrent fault is instead retried on a fixed period from an internal timer. A 3-bit status code shows the current state.

Top module: `amp_supervisor`

## Requirements
- R1: While the synchronized run request is low, the state code is 0 (standby), power_down is 1 and out_en is 0, whatever the play request and the fault flags do.
- R2: With run high, play low and no fault, the state code is 1 (mute): out_en=1, force_mute=1, power_down=0, diag_release=0.
- R3: With run high, play high and no fault, the state code is 2 (play): out_en=1, force_mute=0, power_down=0, diag_release=0.
- R4: An overvoltage or an undervoltage flag gives state code 6 with out_en=0. The user-selected mode returns as soon as both flags are low.
- R5: An overcurrent flag gives state code 4 with out_en=0. That state lasts exactly RETRY_CYCLES cycles. It is followed by state code 5 (retry probe) for exactly one cycle, with out_en=1 and force_mute=1.
- R6: In the probe cycle, an overcurrent flag that is still set sends the block back to state 4, which restarts the full wait. A clear flag lets the block resume according to the remaining inputs.
- R7: A thermal warning gives state code 3: out_en=1, force_mute=1, diag_release=1.
- R8: A thermal shutdown gives state code 7 with out_en=0. The block leaves that state by itself when the flag clears.
- R9: Priority, from highest: standby, then thermal shutdown, then overvoltage/undervoltage, then overcurrent (including a wait already running), then thermal warning, then the user mode. Standby abandons any overcurrent wait.
- R10: Every control and fault input passes through a two-stage synchronizer. A change that is stable before rising edge n shows up on the state code and the outputs just after rising edge n+2.
- R11: diag_release is 1 exactly when the state code is 3, 4, 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Low selects standby |
| play_req | input | 1 | With run high: low = mute, high = play |
| flt_ovp | input | 1 | Supply overvoltage flag |
| flt_uvp | input | 1 | Supply undervoltage flag |
| flt_ocp | input | 1 | Output overcurrent flag |
| flt_twarn | input | 1 | Thermal warning flag |
| flt_tsd | input | 1 | Thermal shutdown flag |
| out_en | output | 1 | Output stage enable (0 = high impedance) |
| force_mute | output | 1 | Command for 50% duty, grounded inputs |
| power_down | output | 1 | Standby power-down command |
| diag_release | output | 1 | 1 = diagnostic pin released (protection active) |
| state_code | output | 3 | Encoded current state |

## Verification
The state code and all four commands change together, just after the third rising edge that follows an input change. Two of those edges belong to the synchronizer and one to the state register. The bench drives inputs on falling edges and pushes them through its own three-edge reference pipeline. It then compares every output on the next falling edge, so each result is sampled half a cycle after the edge that produced it. The overcurrent wait is timed from the cycle the wait state is entered: the probe is due RETRY_CYCLES cycles later and lasts exactly one cycle. A directed check confirms that a new mode is still absent two edges after the change and present after the third.

// File: rtl/amp_supervisor.sv
module amp_supervisor #(
  parameter int RETRY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_req,
  input  logic       play_req,
  input  logic       flt_ovp,
  input  logic       flt_uvp,
  input  logic       flt_ocp,
  input  logic       flt_twarn,
  input  logic       flt_tsd,
  output logic       out_en,
  output logic       force_mute,
  output logic       power_down,
  output logic       diag_release,
  output logic [2:0] state_code
);
  localparam int NIN = 7;
  localparam int TW  = (RETRY_CYCLES < 2) ? 1 : $clog2(RETRY_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(RETRY_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_STBY = 3'd0, ST_MUTE = 3'd1, ST_PLAY = 3'd2, ST_WARN = 3'd3,
    ST_OCW  = 3'd4, ST_PROBE = 3'd5, ST_SUP = 3'd6, ST_TSD = 3'd7
  } st_t;

  logic [NIN-1:0] raw, meta, syn;
  assign raw = {flt_tsd, flt_ovp, flt_uvp, flt_ocp, flt_twarn, play_req, run_req};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      syn  <= '0;
    end else begin
      meta <= raw;
      syn  <= meta;
    end

  wire s_run  = syn[0];
  wire s_play = syn[1];
  wire s_tw   = syn[2];
  wire s_oc   = syn[3];
  wire s_sup  = syn[4] | syn[5];
  wire s_tsd  = syn[6];

  st_t st, st_nx;
  logic [TW-1:0] cnt, cnt_nx;

  function automatic st_t user_or_warn(input logic oc, input logic tw, input logic play);
    if (oc)      return ST_OCW;
    else if (tw) return ST_WARN;
    else if (play) return ST_PLAY;
    else         return ST_MUTE;
  endfunction

  always_comb begin
    st_nx  = st;
    cnt_nx = '0;
    if (!s_run)
      st_nx = ST_STBY;
    else if (s_tsd)
      st_nx = ST_TSD;
    else if (s_sup)
      st_nx = ST_SUP;
    else if (st == ST_OCW) begin
      if (cnt == LAST) st_nx = ST_PROBE;
      else cnt_nx = cnt + 1'b1;
    end else
      st_nx = user_or_warn(s_oc, s_tw, s_play);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_STBY;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  assign state_code   = st;
  assign out_en       = (st == ST_MUTE) | (st == ST_PLAY) | (st == ST_WARN) | (st == ST_PROBE);
  assign force_mute   = (st == ST_MUTE) | (st == ST_WARN) | (st == ST_PROBE);
  assign power_down   = (st == ST_STBY);
  assign diag_release = st[2] | (st == ST_WARN);
endmodule

// File: rtl/amp_supervisor_chk.sv
module amp_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_req,
  input logic       out_en,
  input logic       force_mute,
  input logic       power_down,
  input logic [2:0] state_code
);
  logic [1:0] low_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_run <= '0;
    else if (run_req) low_run <= '0;
    else if (low_run != 2'd3) low_run <= low_run + 2'd1;

  AST_STBY_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run == 2'd3 && !run_req) |=> (power_down && !out_en)); // R1

  AST_PROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5) |=> (state_code != 3'd5)); // R5

  AST_PROBE_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5) |-> ($past(state_code) == 3'd4)); // R5

  AST_WAIT_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4) |=> (state_code inside {3'd0, 3'd4, 3'd5, 3'd6, 3'd7})); // R9

  AST_FAULT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code inside {3'd4, 3'd6, 3'd7}) |-> (!out_en && !power_down && !force_mute)); // R4
endmodule

bind amp_supervisor amp_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_req(run_req), .out_en(out_en),
  .force_mute(force_mute), .power_down(power_down), .state_code(state_code)
);

// File: tb/tb_amp_supervisor.sv
module tb_amp_supervisor;
  localparam int RETRY = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_req = 0, play_req = 0, flt_ovp = 0, flt_uvp = 0, flt_ocp = 0, flt_twarn = 0, flt_tsd = 0;
  logic out_en, force_mute, power_down, diag_release;
  logic [2:0] state_code;
  int checks = 0, fails = 0, probes_refused = 0;
  bit done = 0;

  always #5 clk = ~clk;

  amp_supervisor #(.RETRY_CYCLES(RETRY)) dut (.*);

  // reference: two synchronizer stages, then the state register (R10)
  logic [6:0] m1, m2;
  int ms, mt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; ms <= 0; mt <= 0;
    end else begin
      int ns, nt;
      ns = ms; nt = 0;
      if (!m2[0]) ns = 0;
      else if (m2[6]) ns = 7;
      else if (m2[5] || m2[4]) ns = 6;
      else if (ms == 4) begin
        if (mt == RETRY - 1) ns = 5; else nt = mt + 1;
      end else if (m2[3]) ns = 4;
      else if (m2[2]) ns = 3;
      else ns = m2[1] ? 2 : 1;
      if (ms == 5 && ns == 4) probes_refused++;
      m1 <= {flt_tsd, flt_ovp, flt_uvp, flt_ocp, flt_twarn, play_req, run_req};
      m2 <= m1; ms <= ns; mt <= nt;
    end
  end

  function automatic string tag(input int s);
    case (s)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R7";
      4: return "R5"; 5: return "R6"; 6: return "R4"; default: return "R8";
    endcase
  endfunction

  function automatic logic [3:0] exp_out(input int s);
    logic en, fm, pd, dg;
    en = (s == 1 || s == 2 || s == 3 || s == 5);
    fm = (s == 1 || s == 3 || s == 5);
    pd = (s == 0);
    dg = (s >= 3);
    return {en, fm, pd, dg};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    check(tag(ms), {29'd0, state_code}, ms);
    check("R11", {31'd0, diag_release}, {31'd0, exp_out(ms)[0]});
    check(tag(ms), {28'd0, out_en, force_mute, power_down, diag_release}, {28'd0, exp_out(ms)});
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_now();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", {29'd0, state_code}, 0);
    check("R1", {31'd0, power_down}, 1);
    rst_n = 1'b1;
    run_cycles(4);
    // R1: play request ignored in standby
    play_req = 1; run_cycles(5);
    check("R1", {29'd0, state_code}, 0);
    // R10: latency three edges
    run_req = 1;
    @(negedge clk); @(negedge clk);
    check("R10", {29'd0, state_code}, 0);
    @(negedge clk);
    check("R10", {29'd0, state_code}, 2);
    run_cycles(3);
    // R5/R6: persistent overcurrent, then release after a probe
    flt_ocp = 1; run_cycles(3 * (RETRY + 1) + 5);
    check("R6", {31'd0, (probes_refused > 0)}, 1);
    flt_ocp = 0; run_cycles(RETRY + 6);
    check("R6", {29'd0, state_code}, 2);
    // R9: shutdown beats supply fault beats warning
    flt_twarn = 1; flt_ovp = 1; flt_tsd = 1; run_cycles(5);
    check("R9", {29'd0, state_code}, 7);
    flt_tsd = 0; run_cycles(4);
    check("R9", {29'd0, state_code}, 6);
    flt_ovp = 0; run_cycles(4);
    check("R9", {29'd0, state_code}, 3);
    flt_twarn = 0; play_req = 0; run_cycles(4);
    check("R2", {29'd0, state_code}, 1);
    // R9: standby aborts an overcurrent wait
    flt_ocp = 1; run_cycles(6); run_req = 0; flt_ocp = 0; run_cycles(4);
    check("R9", {29'd0, state_code}, 0);
    // random phase
    for (int b = 0; b < 400; b++) begin
      int hold;
      hold = 1 + int'($urandom % 40);
      run_req   = ($urandom % 10) != 0;
      play_req  = $urandom % 2;
      flt_tsd   = ($urandom % 12) == 0;
      flt_ovp   = ($urandom % 10) == 0;
      flt_uvp   = ($urandom % 10) == 0;
      flt_ocp   = ($urandom % 6) == 0;
      flt_twarn = ($urandom % 6) == 0;
      run_cycles(hold);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule